// File: doc/BRIEF.md
# Per-Channel Slave Select Decoder

This block is the address-decode stage of a lightweight AXI4-Lite style interconnect with one master and a fixed set of slaves. Each slave has a base address, a local word-address width and a data width, all set by parameters. For every slave the block registers four separate selects, one for each of the write-address, write-data, read-address and read-data channels. Each select is gated by the handshake signal of its own channel.

The read and write addresses arrive on separate inputs, so the two directions decode independently and can point at different slaves in the same cycle. For each slave the block also cuts the local word address out of both the read and the write address. Before it takes the local address it removes the byte-offset bits, whose number depends on the slave's data width. The routing, arbitration and response logic around the block use these selects and local addresses.

Top module: `addr_chan_decoder`

## Requirements
- R1: When `rst_n` is 0 at a rising clock edge, all sixteen selects (`aw_sel`, `w_sel`, `ar_sel`, `r_sel`) are 0 after that edge, whatever the address and handshake inputs are.
- R2: For a slave with local width W > 1 and data width D, the byte shift is S = log2(D/8). The slave's local write address, in field i of `slv_waddr` (bits i*8+7..i*8), is `wr_addr[W+S-1:S]` with zeros above. Field i of `slv_raddr` takes the same slice of `rd_addr`. The output is combinational.
- R3: For a slave with a local width of 1, the local address is bit 1 of the master address, on both the read path and the write path, with zeros above.
- R4: After each rising edge with `rst_n` at 1, `aw_sel[i]` is 1 exactly when `aw_valid` was 1 and the write address matched slave i at that edge.
- R5: After each such edge, `w_sel[i]` is 1 exactly when `w_valid` was 1 and the write address matched slave i.
- R6: After each such edge, `ar_sel[i]` is 1 exactly when `ar_valid` was 1 and the read address matched slave i.
- R7: After each such edge, `r_sel[i]` is 1 exactly when `r_ready` was 1 and the read address matched slave i.
- R8: An address matches slave i when its bits from 31 down to W+S are equal to the same bits of that slave's base. Addresses one byte below or past the end of the region do not match.
- R9: With the default aligned, non-overlapping regions, at most one bit of each select vector is 1.
- R10: Read selects depend only on `rd_addr` and the read handshakes. Write selects depend only on `wr_addr` and the write handshakes. When the two addresses point at different slaves at the same time, each direction selects its own slave.

Default slaves (index: base, W, D): 0: 0x1000, 4, 32; 1: 0x2000, 1, 32; 2: 0x3000, 3, 64; 3: 0x4000, 8, 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_addr | input | 32 | Write address from the master |
| rd_addr | input | 32 | Read address from the master |
| aw_valid | input | 1 | Write-address channel valid |
| w_valid | input | 1 | Write-data channel valid |
| ar_valid | input | 1 | Read-address channel valid |
| r_ready | input | 1 | Read-data channel ready |
| aw_sel | output | 4 | Registered write-address select, one bit per slave |
| w_sel | output | 4 | Registered write-data select, one bit per slave |
| ar_sel | output | 4 | Registered read-address select, one bit per slave |
| r_sel | output | 4 | Registered read-data select, one bit per slave |
| slv_waddr | output | 32 | Local write word address, 8 bits per slave |
| slv_raddr | output | 32 | Local read word address, 8 bits per slave |

## Verification
The selects are due one rising edge after the address and handshake they depend on. The local addresses are due in the same cycle as the address, because they come from wiring alone. The bench changes its inputs on the falling edge. Before each change it compares the local addresses against the inputs still applied, and compares the selects against a reference that was updated at the rising edge just passed. That reference holds exactly one register stage, so every select is judged in the cycle it is due. Directed phases drive region boundaries, one-bit slaves, reset while the handshakes are active, and reads and writes to different slaves at the same time. A randomized phase follows.

// File: rtl/addr_dec_pkg.sv
// Package: helpers shared by the decoder modules.
// Assumes data widths are powers of two and at least 8 bits.
package addr_dec_pkg;

    // Number of byte-offset bits below a word of the given data width.
    function automatic int byte_shift(input int data_w);
        return $clog2(data_w / 8);
    endfunction

endpackage

// File: rtl/addr_slice_match.sv
// Module: addr_slice_match
// Compares one master address with one slave region and cuts out the
// slave-local word address. Purely combinational.
// Assumes LOC_W <= LOC_MAX and LOC_W + SHIFT < ADDR_W.
module addr_slice_match #(
    parameter int ADDR_W  = 32,
    parameter int LOC_MAX = 8,
    parameter int LOC_W   = 4,
    parameter int SHIFT   = 2,
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit,
    output logic [LOC_MAX-1:0] loc
);
    localparam int CMP_LO = LOC_W + SHIFT;

    logic unused_bits;

    // Keep every address bit referenced so that no slice width leaves a bit dangling.
    assign unused_bits = ^addr;

    // Region match on the bits above the slave's local span.
    assign hit = (addr[ADDR_W-1:CMP_LO] == BASE[ADDR_W-1:CMP_LO]);

    // Local address: a one-bit slave always takes bit 1, wider slaves skip the byte offset.
    generate
        if (LOC_W == 0) begin : g_none
            assign loc = '0;
        end else if (LOC_W == 1) begin : g_one
            assign loc = LOC_MAX'(addr[1]);
        end else begin : g_wide
            assign loc = LOC_MAX'(addr[LOC_W+SHIFT-1:SHIFT]);
        end
    endgenerate

endmodule

// File: rtl/chan_sel.sv
// Module: chan_sel
// Registers the select vector of one channel: the match vector gated by
// that channel's handshake. Synchronous active-low reset clears it.
// Assumes the match vector is already stable before the clock edge.
module chan_sel #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    input  logic         qual,
    output logic [N-1:0] sel
);
    // Select register: follows the match only while the handshake is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
        end else if (qual) begin
            sel <= hit;
        end else begin
            sel <= '0;
        end
    end

endmodule

// File: rtl/addr_chan_decoder.sv
// Module: addr_chan_decoder
// Top-level address decode for one master and N_SLV slaves. It decodes the
// read and write addresses separately and registers four select vectors,
// one for each channel. It also exposes the local word address for each slave.
// Assumes the slave regions are aligned to their size and do not overlap.
module addr_chan_decoder #(
    parameter int ADDR_W  = 32,
    parameter int N_SLV   = 4,
    parameter int LOC_MAX = 8,
    parameter logic [N_SLV-1:0][ADDR_W-1:0] SLV_BASE =
        {32'h0000_4000, 32'h0000_3000, 32'h0000_2000, 32'h0000_1000},
    parameter logic [N_SLV-1:0][7:0]  SLV_LOCW = {8'd8, 8'd3, 8'd1, 8'd4},
    parameter logic [N_SLV-1:0][15:0] SLV_DW   = {16'd8, 16'd64, 16'd32, 16'd32}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic                     aw_valid,
    input  logic                     w_valid,
    input  logic                     ar_valid,
    input  logic                     r_ready,
    output logic [N_SLV-1:0]         aw_sel,
    output logic [N_SLV-1:0]         w_sel,
    output logic [N_SLV-1:0]         ar_sel,
    output logic [N_SLV-1:0]         r_sel,
    output logic [N_SLV*LOC_MAX-1:0] slv_waddr,
    output logic [N_SLV*LOC_MAX-1:0] slv_raddr
);
    logic [N_SLV-1:0]              w_hit;
    logic [N_SLV-1:0]              r_hit;
    logic [N_SLV-1:0][LOC_MAX-1:0] w_loc;
    logic [N_SLV-1:0][LOC_MAX-1:0] r_loc;

    // One matcher per slave on each address path.
    generate
        for (genvar i = 0; i < N_SLV; i++) begin : g_slv
            localparam int LW = int'(SLV_LOCW[i]);
            localparam int SH = addr_dec_pkg::byte_shift(int'(SLV_DW[i]));

            addr_slice_match #(
                .ADDR_W (ADDR_W),
                .LOC_MAX(LOC_MAX),
                .LOC_W  (LW),
                .SHIFT  (SH),
                .BASE   (SLV_BASE[i])
            ) i_wmatch (
                .addr(wr_addr),
                .hit (w_hit[i]),
                .loc (w_loc[i])
            );

            addr_slice_match #(
                .ADDR_W (ADDR_W),
                .LOC_MAX(LOC_MAX),
                .LOC_W  (LW),
                .SHIFT  (SH),
                .BASE   (SLV_BASE[i])
            ) i_rmatch (
                .addr(rd_addr),
                .hit (r_hit[i]),
                .loc (r_loc[i])
            );
        end
    endgenerate

    assign slv_waddr = w_loc;
    assign slv_raddr = r_loc;

    // Four channel select registers: write paths use the write match, read paths the read match.
    chan_sel #(.N(N_SLV)) i_aw (.clk(clk), .rst_n(rst_n), .hit(w_hit), .qual(aw_valid), .sel(aw_sel));
    chan_sel #(.N(N_SLV)) i_w  (.clk(clk), .rst_n(rst_n), .hit(w_hit), .qual(w_valid),  .sel(w_sel));
    chan_sel #(.N(N_SLV)) i_ar (.clk(clk), .rst_n(rst_n), .hit(r_hit), .qual(ar_valid), .sel(ar_sel));
    chan_sel #(.N(N_SLV)) i_r  (.clk(clk), .rst_n(rst_n), .hit(r_hit), .qual(r_ready),  .sel(r_sel));

    // R1: a reset edge leaves every select cleared.
    p_rst_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (aw_sel == '0 && w_sel == '0 && ar_sel == '0 && r_sel == '0));

    // R4: a write-address select needs aw_valid at the edge before.
    p_aw_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_sel != '0) |-> $past(aw_valid));

    // R5: a write-data select needs w_valid at the edge before.
    p_w_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (w_sel != '0) |-> $past(w_valid));

    // R6: a read-address select needs ar_valid at the edge before.
    p_ar_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_sel != '0) |-> $past(ar_valid));

    // R7: a read-data select needs r_ready at the edge before.
    p_r_needs_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_sel != '0) |-> $past(r_ready));

    // R9: at most one slave is selected on each channel.
    p_onehot_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(aw_sel) && $onehot0(w_sel) && $onehot0(ar_sel) && $onehot0(r_sel));

    // R10: a stable read path with no read handshake keeps the read selects at zero.
    p_read_isolated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ar_valid && !r_ready) |=> (ar_sel == '0 && r_sel == '0));

endmodule

// File: tb/test_addr_chan_decoder.sv
// Bench for addr_chan_decoder. A behavioural reference computes the expected
// match and local address arithmetically and keeps one register stage for
// the selects. The bench compares against it on every falling edge.
module test_addr_chan_decoder;
    localparam int NS = 4;
    localparam int LM = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic [31:0]       wr_addr, rd_addr;
    logic              aw_valid, w_valid, ar_valid, r_ready;
    logic [NS-1:0]     aw_sel, w_sel, ar_sel, r_sel;
    logic [NS*LM-1:0]  slv_waddr, slv_raddr;

    addr_chan_decoder i_addr_chan_decoder (
        .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .aw_valid(aw_valid), .w_valid(w_valid), .ar_valid(ar_valid), .r_ready(r_ready),
        .aw_sel(aw_sel), .w_sel(w_sel), .ar_sel(ar_sel), .r_sel(r_sel),
        .slv_waddr(slv_waddr), .slv_raddr(slv_raddr)
    );

    int unsigned m_base [NS] = '{32'h1000, 32'h2000, 32'h3000, 32'h4000};
    int          m_locw [NS] = '{4, 1, 3, 8};
    int          m_shift[NS] = '{2, 2, 3, 0};

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string ctx   = "reset";

    function automatic logic [NS-1:0] ref_hit(input logic [31:0] a);
        logic [NS-1:0] r;
        for (int i = 0; i < NS; i++) begin
            int lo = m_locw[i] + m_shift[i];
            r[i] = ((a >> lo) == (m_base[i] >> lo));
        end
        return r;
    endfunction

    function automatic logic [LM-1:0] ref_loc(input logic [31:0] a, input int i);
        if (m_locw[i] == 1) return LM'(a[1]);
        return LM'((a >> m_shift[i]) & ((32'd1 << m_locw[i]) - 1));
    endfunction

    logic [NS-1:0] e_aw, e_w, e_ar, e_r;
    bit            e_rst;

    // Reference register stage.
    always @(posedge clk) begin
        if (!rst_n) begin
            e_aw <= '0; e_w <= '0; e_ar <= '0; e_r <= '0; e_rst <= 1'b1;
        end else begin
            e_aw  <= aw_valid ? ref_hit(wr_addr) : '0;
            e_w   <= w_valid  ? ref_hit(wr_addr) : '0;
            e_ar  <= ar_valid ? ref_hit(rd_addr) : '0;
            e_r   <= r_ready  ? ref_hit(rd_addr) : '0;
            e_rst <= 1'b0;
        end
    end

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] t=%0t actual=%h expected=%h", tag, ctx, $time, act, exp);
        end
    endtask

    task automatic check_all();
        cmp(e_rst ? "R1 aw_sel" : "R4 aw_sel", 32'(aw_sel), 32'(e_aw));
        cmp(e_rst ? "R1 w_sel"  : "R5 w_sel",  32'(w_sel),  32'(e_w));
        cmp(e_rst ? "R1 ar_sel" : "R6 ar_sel", 32'(ar_sel), 32'(e_ar));
        cmp(e_rst ? "R1 r_sel"  : "R7 r_sel",  32'(r_sel),  32'(e_r));
        cmp("R9 onehot", 32'($countones(aw_sel) <= 1 && $countones(w_sel) <= 1 &&
                             $countones(ar_sel) <= 1 && $countones(r_sel) <= 1), 32'd1);
        for (int i = 0; i < NS; i++) begin
            cmp(m_locw[i] == 1 ? "R3 wloc" : "R2 wloc",
                32'(slv_waddr[i*LM +: LM]), 32'(ref_loc(wr_addr, i)));
            cmp(m_locw[i] == 1 ? "R3 rloc" : "R2 rloc",
                32'(slv_raddr[i*LM +: LM]), 32'(ref_loc(rd_addr, i)));
        end
    endtask

    // One cycle: check what is due, then apply new inputs.
    task automatic step(input bit r, input logic [31:0] wa, input logic [31:0] ra,
                        input logic [3:0] hs);
        @(negedge clk);
        check_all();
        rst_n = r; wr_addr = wa; rd_addr = ra;
        {aw_valid, w_valid, ar_valid, r_ready} = hs;
    endtask

    function automatic logic [31:0] pick_addr(input int unsigned x);
        return m_base[x % NS] + ((x >> 4) & 32'h1FF);
    endfunction

    initial begin
        rst_n = 1'b0; wr_addr = '0; rd_addr = '0;
        aw_valid = 0; w_valid = 0; ar_valid = 0; r_ready = 0;
        // R1: reset with every handshake active and addresses inside regions.
        ctx = "R1 reset";
        step(0, 32'h1004, 32'h3008, 4'hF);
        step(0, 32'h2002, 32'h4010, 4'hF);
        step(1, 32'h1004, 32'h3008, 4'hF);
        // R8: region edges, one byte in and one byte out.
        ctx = "R8 boundary";
        step(1, 32'h103F, 32'h1040, 4'hF);
        step(1, 32'h0FFF, 32'h1000, 4'hF);
        step(1, 32'h2007, 32'h2008, 4'hF);
        step(1, 32'h303F, 32'h40FF, 4'hF);
        step(1, 32'h4100, 32'h2FFF, 4'hF);
        // R3: one-bit slave local address from bit 1.
        ctx = "R3 one-bit";
        step(1, 32'h2002, 32'h2006, 4'hA);
        step(1, 32'h2004, 32'h2000, 4'h5);
        // R10: concurrent reads and writes to different slaves, each handshake alone.
        ctx = "R10 concurrent";
        step(1, 32'h1010, 32'h3018, 4'h8);
        step(1, 32'h4022, 32'h2004, 4'h4);
        step(1, 32'h3020, 32'h1008, 4'h2);
        step(1, 32'h2004, 32'h4033, 4'h1);
        step(1, 32'h1010, 32'h3018, 4'h0);
        step(1, 32'h1010, 32'h3018, 4'hC);
        step(1, 32'h1010, 32'h3018, 4'h3);
        // Randomized traffic with a mid-run reset.
        ctx = "random";
        for (int k = 0; k < 2000; k++) begin
            int unsigned x = $urandom;
            int unsigned y = $urandom;
            step((k % 500) != 250, pick_addr(x), pick_addr(y), 4'(y >> 20));
        end
        step(1, 32'h0, 32'h0, 4'h0);
        step(1, 32'h0, 32'h0, 4'h0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule